// File: doc/BRIEF.md
# Multi-size condition code generator

This unit sits behind a 32-bit ALU that executes every arithmetic and logic operation at full width. On each operation it derives three condition-code sets in parallel. The first is the set an 8-bit operation would have produced, the second is the 16-bit set and the third is the 32-bit set. All three are written into separate flag registers. Software that emulates a processor with byte, word and long operand sizes then reads the register for the size it needs. It does not have to rebuild the flags from the full-width result.

The unit takes the two operands, the ALU result, the raw adder carry-outs at bits 7, 15 and 31, a 2-bit operation class and a write enable. It does not compute the result itself. Each flag register follows the usual rules of a flag set that has an extend bit. Arithmetic copies the carry into extend. Logic and moves clear carry and overflow and leave extend alone. Compare sets carry and overflow but does not touch extend.

Top module: `mscc_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three flag registers become 5'b00000 on that edge.
- R2: When `wr_en` is low at a rising edge, all three flag registers keep their previous values, whatever the other inputs are.
- R3: N in the byte, word and long registers equals result bit 7, bit 15 and bit 31 respectively.
- R4: Z in the byte, word and long registers is 1 exactly when result bits [7:0], [15:0] and [31:0] respectively are all zero.
- R5: For class 2'b00 (add), C equals the carry-out input for that slice. Input bit 0 is the carry at bit 7, bit 1 at bit 15 and bit 2 at bit 31. V is 1 when the slice-wide signed sum of the operand slices overflows.
- R6: For class 2'b01 (subtract, result = a - b), the carry input is the raw adder carry of a + ~b + 1. C is its inverse, that is, the borrow: 1 exactly when the unsigned slice of a is less than that of b. V is 1 when the slice-wide signed difference overflows.
- R7: For add and subtract, X is set equal to the new C in each register.
- R8: For class 2'b10 (logic or move), V and C are cleared and X keeps its previous value in each register. The carry inputs are ignored.
- R9: For class 2'b11 (compare), N, Z, V and C follow the subtract rules and X keeps its previous value.
- R10: Each flag register is laid out as bit 4 = X, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R11: All three registers update on the same clock edge as the write that produced them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Update all flag registers this cycle |
| op_class | input | 2 | 00 add, 01 subtract, 10 logic/move, 11 compare |
| op_a | input | 32 | First ALU operand |
| op_b | input | 32 | Second ALU operand |
| alu_res | input | 32 | ALU result |
| carry_out | input | 3 | Raw adder carry at bit 7 (bit 0), bit 15 (bit 1), bit 31 (bit 2) |
| ccr_byte | output | 5 | Flags as if the operation were 8-bit |
| ccr_word | output | 5 | Flags as if the operation were 16-bit |
| ccr_long | output | 5 | Flags as if the operation were 32-bit |

## Verification
The only state in the unit is the three flag registers, and every one of their bits is visible on the outputs one edge after the write. A wrong N, Z, V or C therefore shows up at the port in the cycle right after the faulty operation. A corrupted X is different. It can stay hidden through logic and compare operations, which preserve it, and it is seen only when those operations are compared against a model that carries X forward. The bench mixes those classes deliberately so that a lost X becomes visible within a few operations.

// File: rtl/mscc_pkg.sv
package mscc_pkg;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_LOGIC = 2'b10,
        CLS_CMP   = 2'b11
    } op_class_e;

    // bit 4 = x, bit 3 = n, bit 2 = z, bit 1 = v, bit 0 = c
    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } arith_flags_t;

endpackage

// File: rtl/mscc_slice_eval.sv
module mscc_slice_eval
    import mscc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              carry_raw,
    input  logic              is_sub,
    output arith_flags_t      flags
);
    localparam int TOP = SLICE_W - 1;

    logic sign_a;
    logic sign_b_eff;
    logic sign_r;

    always_comb begin
        sign_a     = op_a[TOP];
        // subtraction adds the inverted second operand
        sign_b_eff = op_b[TOP] ^ is_sub;
        sign_r     = alu_res[TOP];
        flags.n    = sign_r;
        flags.z    = ~|alu_res[TOP:0];
        flags.v    = (sign_a == sign_b_eff) && (sign_r != sign_a);
        // raw adder carry becomes a borrow for subtraction
        flags.c    = carry_raw ^ is_sub;
    end

endmodule

// File: rtl/mscc_flag_merge.sv
module mscc_flag_merge
    import mscc_pkg::*;
(
    input  op_class_e    cls,
    input  arith_flags_t arith,
    input  ccr_t         prev,
    output ccr_t         next
);
    always_comb begin
        next   = prev;
        next.n = arith.n;
        next.z = arith.z;
        unique case (cls)
            CLS_ADD, CLS_SUB: begin
                next.v = arith.v;
                next.c = arith.c;
                next.x = arith.c;
            end
            CLS_CMP: begin
                next.v = arith.v;
                next.c = arith.c;
            end
            default: begin
                next.v = 1'b0;
                next.c = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mscc_gen.sv
module mscc_gen
    import mscc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BASE_W    = 8,
    parameter int NUM_SIZES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           op_class,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [DATA_W-1:0]    op_b,
    input  logic [DATA_W-1:0]    alu_res,
    input  logic [NUM_SIZES-1:0] carry_out,
    output logic [4:0]           ccr_byte,
    output logic [4:0]           ccr_word,
    output logic [4:0]           ccr_long
);
    localparam int LAST = NUM_SIZES - 1;

    op_class_e cls;
    logic      is_sub;

    ccr_t [NUM_SIZES-1:0]         ccr_d;
    ccr_t [NUM_SIZES-1:0]         ccr_q;
    ccr_t [NUM_SIZES-1:0]         merged;
    arith_flags_t [NUM_SIZES-1:0] arith;

    always_comb begin
        cls    = op_class_e'(op_class);
        is_sub = (cls == CLS_SUB) || (cls == CLS_CMP);
    end

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        mscc_slice_eval #(
            .DATA_W  (DATA_W),
            .SLICE_W (BASE_W << g)
        ) eval_i (
            .op_a      (op_a),
            .op_b      (op_b),
            .alu_res   (alu_res),
            .carry_raw (carry_out[g]),
            .is_sub    (is_sub),
            .flags     (arith[g])
        );

        mscc_flag_merge merge_i (
            .cls   (cls),
            .arith (arith[g]),
            .prev  (ccr_q[g]),
            .next  (merged[g])
        );
    end

    always_comb begin
        ccr_d = ccr_q;
        if (wr_en) begin
            ccr_d = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= '0;
        end else begin
            ccr_q <= ccr_d;
        end
    end

    assign ccr_byte = ccr_q[0];
    assign ccr_word = ccr_q[1];
    assign ccr_long = ccr_q[LAST];

endmodule

// File: rtl/mscc_gen_chk.sv
module mscc_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  op_class,
    input logic [31:0] alu_res,
    input logic [4:0]  ccr_byte,
    input logic [4:0]  ccr_word,
    input logic [4:0]  ccr_long
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ccr_byte == 5'd0 && ccr_word == 5'd0 && ccr_long == 5'd0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ccr_byte) && $stable(ccr_word) && $stable(ccr_long)));

    assert_sign_long_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ccr_long[3] == $past(alu_res[31]) && ccr_byte[3] == $past(alu_res[7])));

    assert_zero_word_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ccr_word[2] == ($past(alu_res[15:0]) == 16'd0)));

    assert_ext_follows_carry_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !op_class[1]) |=>
            (ccr_byte[4] == ccr_byte[0] && ccr_word[4] == ccr_word[0] && ccr_long[4] == ccr_long[0]));

    assert_logic_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_class == 2'b10) |=>
            (ccr_byte[1:0] == 2'b00 && ccr_word[1:0] == 2'b00 && ccr_long[1:0] == 2'b00
             && ccr_long[4] == $past(ccr_long[4]) && ccr_byte[4] == $past(ccr_byte[4])));

    assert_cmp_keeps_ext_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op_class == 2'b11) |=>
            (ccr_byte[4] == $past(ccr_byte[4]) && ccr_word[4] == $past(ccr_word[4])
             && ccr_long[4] == $past(ccr_long[4])));

endmodule

bind mscc_gen mscc_gen_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .op_class (op_class),
    .alu_res  (alu_res),
    .ccr_byte (ccr_byte),
    .ccr_word (ccr_word),
    .ccr_long (ccr_long)
);

// File: tb/mscc_gen_tb.sv
module mscc_gen_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  op_class = 2'b00;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] alu_res = '0;
    logic [2:0]  carry_out = '0;
    logic [4:0]  ccr_byte;
    logic [4:0]  ccr_word;
    logic [4:0]  ccr_long;

    int checks = 0;
    int fails = 0;
    logic [4:0] model [3];

    always #(CLK_P/2) clk = ~clk;

    mscc_gen dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .op_class(op_class),
        .op_a(op_a), .op_b(op_b), .alu_res(alu_res), .carry_out(carry_out),
        .ccr_byte(ccr_byte), .ccr_word(ccr_word), .ccr_long(ccr_long)
    );

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [4:0] dut_reg(int s);
        if (s == 0) return ccr_byte;
        if (s == 1) return ccr_word;
        return ccr_long;
    endfunction

    function automatic longint sgn(longint v, int w);
        longint half = longint'(1) << (w - 1);
        return (v >= half) ? v - (longint'(1) << w) : v;
    endfunction

    task automatic step(bit we, logic [1:0] cls, logic [31:0] a, logic [31:0] b);
        logic [31:0] res;
        logic [2:0]  cy;
        string       tx, tvc;
        res = (cls == 2'b00) ? a + b : (cls == 2'b10) ? (a | b) : a - b;
        for (int s = 0; s < 3; s++) begin
            int w = 8 << s;
            longint mask = (longint'(1) << w) - 1;
            longint ra = longint'(a) & mask;
            longint rb = longint'(b) & mask;
            if (cls == 2'b00) cy[s] = (((ra + rb) >> w) & 1) != 0;
            else if (cls == 2'b10) cy[s] = 1'b1;
            else cy[s] = (((ra + ((~rb) & mask) + 1) >> w) & 1) != 0;
        end
        @(negedge clk);
        wr_en = we; op_class = cls; op_a = a; op_b = b; alu_res = res; carry_out = cy;
        @(posedge clk);
        #1;
        tx  = (cls == 2'b10) ? "R8" : (cls == 2'b11) ? "R9" : "R7";
        tvc = (cls == 2'b00) ? "R5" : (cls == 2'b01) ? "R6" : (cls == 2'b10) ? "R8" : "R9";
        for (int s = 0; s < 3; s++) begin
            int w = 8 << s;
            longint mask = (longint'(1) << w) - 1;
            longint ra = longint'(a) & mask;
            longint rb = longint'(b) & mask;
            longint sr;
            logic n, z, v, c, x;
            x = model[s][4];
            n = res[w-1];
            z = ((longint'(res) & mask) == 0);
            v = 1'b0; c = 1'b0;
            if (cls == 2'b00) begin
                c = (ra + rb) > mask;
                sr = sgn(ra, w) + sgn(rb, w);
                v = (sr >= (longint'(1) << (w-1))) || (sr < -(longint'(1) << (w-1)));
                x = c;
            end else if (cls != 2'b10) begin
                c = ra < rb;
                sr = sgn(ra, w) - sgn(rb, w);
                v = (sr >= (longint'(1) << (w-1))) || (sr < -(longint'(1) << (w-1)));
                if (cls == 2'b01) x = c;
            end
            if (we) begin
                model[s] = {x, n, z, v, c};
                chk(tx,   $sformatf("X size%0d", s), dut_reg(s)[4], x);
                chk("R3", $sformatf("N size%0d", s), dut_reg(s)[3], n);
                chk("R4", $sformatf("Z size%0d", s), dut_reg(s)[2], z);
                chk(tvc,  $sformatf("V size%0d", s), dut_reg(s)[1], v);
                chk(tvc,  $sformatf("C size%0d", s), dut_reg(s)[0], c);
            end else begin
                chk("R2", $sformatf("hold size%0d", s), dut_reg(s), model[s]);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1;
        @(posedge clk);
        #1;
        for (int s = 0; s < 3; s++) begin
            model[s] = 5'd0;
            chk("R1", $sformatf("reset size%0d", s), dut_reg(s), 0);
        end
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 3; s++) model[s] = 5'd0;
        repeat (3) @(posedge clk);
        do_reset();
        // byte carry, byte zero; layout and simultaneous update
        step(1, 2'b00, 32'h0000_00FF, 32'h0000_0001);
        chk("R10", "byte layout", ccr_byte, 5'b10101);
        chk("R11", "word same edge", ccr_word, 5'b00000);
        chk("R11", "long same edge", ccr_long, 5'b00000);
        step(1, 2'b00, 32'h0000_007F, 32'h0000_0001);
        step(1, 2'b00, 32'h0000_FFFF, 32'h0000_0001);
        step(1, 2'b00, 32'h7FFF_FFFF, 32'h0000_0001);
        step(1, 2'b00, 32'hFFFF_FFFF, 32'h0000_0001);
        step(1, 2'b10, 32'h0000_0000, 32'h0000_0000);
        step(1, 2'b11, 32'h0000_0000, 32'h0000_0001);
        step(0, 2'b01, 32'h1234_5678, 32'hFFFF_FFFF);
        step(1, 2'b01, 32'h0000_0000, 32'h0000_0001);
        step(1, 2'b01, 32'h0000_0080, 32'h0000_0001);
        step(1, 2'b10, 32'h8000_8080, 32'h0000_0000);
        step(1, 2'b11, 32'h0000_0005, 32'h0000_0005);
        step(1, 2'b01, 32'h8000_0000, 32'h0000_0001);
        step(0, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = (i % 5 == 0) ? a : $urandom;
            step(($urandom % 4) != 0, 2'($urandom), a, b);
        end
        do_reset();
        step(0, 2'b00, 32'h0000_00FF, 32'h0000_0001);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule